// File: doc/BRIEF.md
# Flash Chip-Erase Sequencer

This controller sits on the host side of a word-wide flash device that takes its commands through writes to a command register. One start pulse makes it erase the whole array. The first phase programs every word to zero with a program/verify loop, so that all cells start the erase from the same charge state. The second phase launches erase pulses and checks the array word by word until every word reads all ones. It stops with a pass flag when every word is blank, and with a fail flag when the retry budget runs out.

The flash is driven through a single-cycle bus: a write strobe that carries an address and a data word, and a read strobe whose data comes back in the following cycle. While a run is in progress, a programming-voltage request output stays high. Every wait the flash needs (supply settle, program pulse, erase pulse, verify settle) is a clock-cycle count parameter, so a bench can shrink them.

When a verify read fails during erase, the word's address is kept. After one more erase pulse, checking resumes at that word. A single pulse counter covers the whole run and bounds the total number of erase pulses.

Top module: `flash_erase_seq`

## Requirements
- R1: While reset is held and after it is released, busy, pass, fail, vpp_req, fl_wr and fl_rd are all low.
- R2: A start seen while idle raises busy and vpp_req in the next cycle. The first strobe follows after exactly VPP_WAIT cycles without any strobe. Until the run ends, busy and vpp_req stay high and pass and fail stay low.
- R3: Preconditioning visits the words in ascending order from address 0. For each word: a write of 40h; in the next cycle, a write of data 0000h to that word's address; PROG_WAIT quiet cycles; a write of C0h; VERIFY_WAIT quiet cycles; a read of the word. The read data is taken in the cycle after the read strobe. If it is not 0000h, the same word is programmed again, starting the cycle after the compare.
- R4: If a word still differs from 0000h after PROG_MAX program writes, fail rises and busy falls in the cycle after that compare, and no erase is ever launched.
- R5: No erase is launched before every word has verified as 0000h.
- R6: An erase is launched by writes of 20h in two consecutive cycles. After the second write come ERASE_WAIT quiet cycles, then a write of A0h that carries the address of the word to check.
- R7: Every A0h write is followed by VERIFY_WAIT quiet cycles and then a read of the same address. A result of FFFFh moves on to the next address, whose A0h write comes in the cycle after the compare.
- R8: A result other than FFFFh starts a new erase launch (20h, 20h) in the cycle after the compare. Verification then resumes at that same address, not at address 0.
- R9: Erase launches are counted from start over the whole run. A mismatch seen after PULSE_LIMIT launches ends the run with fail in the next cycle, so no run makes more than PULSE_LIMIT launches.
- R10: When the last address reads FFFFh, a write of 00h follows in the next cycle. In the cycle after that write, busy and vpp_req are low and pass is high.
- R11: A start pulse while busy is ignored: the command sequence and its timing do not change.
- R12: Pass and fail are never high together, and never high while busy. Each holds until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Single-cycle request to erase the whole array |
| busy | output | 1 | A run is in progress |
| pass | output | 1 | The last run ended with every word blank |
| fail | output | 1 | The last run gave up |
| vpp_req | output | 1 | Request for the high programming voltage |
| fl_wr | output | 1 | Write strobe to the flash command bus |
| fl_rd | output | 1 | Read strobe to the flash bus |
| fl_addr | output | AW | Word address for the strobe |
| fl_wdata | output | DW | Command code or data for a write |
| fl_rdata | input | DW | Read data, valid in the cycle after fl_rd |

## Verification
A start request can arrive in the same cycle as a command strobe or a verify compare. The bench provokes this by pulsing start twice in the middle of a run, once in a wait window and once on a strobe. It then judges the run against a trace computed beforehand, which must match in every cycle and every field. A second meeting point is a verify compare that mismatches on the very cycle the pulse counter reaches its limit. Word retry needs placed on both sides of the limit show whether that compare ends the run or launches one more erase.

// File: rtl/ferase_pkg.sv
package ferase_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WAIT,
      ST_PSET,
      ST_PDATA,
      ST_PVSET,
      ST_PVRD,
      ST_PVCHK,
      ST_ESET,
      ST_EGO,
      ST_EVSET,
      ST_EVRD,
      ST_EVCHK,
      ST_RDMODE
   } seq_state_t;

   localparam logic [7:0] OP_READ      = 8'h00;
   localparam logic [7:0] OP_PROG      = 8'h40;
   localparam logic [7:0] OP_PROG_VFY  = 8'hC0;
   localparam logic [7:0] OP_ERASE     = 8'h20;
   localparam logic [7:0] OP_ERASE_VFY = 8'hA0;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/ferase_wait_timer.sv
module ferase_wait_timer #(
   parameter int unsigned TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);

   // The sequencer only reloads a timer that has run out (R2 wait spacing)
   a_r2_reload_only_expired: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> expired);

endmodule

// File: rtl/ferase_limit_cnt.sv
module ferase_limit_cnt #(
   parameter int unsigned LIMIT = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic full
);

   localparam int unsigned CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("ferase_limit_cnt: LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (inc && !full) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign full = (cnt == CW'(LIMIT));

   // The sequencer must have stopped before asking for one more pulse
   a_r9_no_count_past_limit: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !inc);

endmodule

// File: rtl/ferase_addr_walk.sv
module ferase_addr_walk #(
   parameter int unsigned AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          last
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (clr) begin
         addr <= '0;
      end else if (step) begin
         addr <= addr + 1'b1;
      end
   end

   assign last = &addr;

   // A step past the top word would wrap to address 0 (R7, R8)
   a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> !last);

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import ferase_pkg::*;
#(
   parameter int unsigned AW          = 16,
   parameter int unsigned DW          = 16,
   parameter int unsigned VPP_WAIT    = 250,
   parameter int unsigned PROG_WAIT   = 2500,
   parameter int unsigned ERASE_WAIT  = 2500000,
   parameter int unsigned VERIFY_WAIT = 1500,
   parameter int unsigned PROG_MAX    = 25,
   parameter int unsigned PULSE_LIMIT = 1000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          pass,
   output logic          fail,
   output logic          vpp_req,
   output logic          fl_wr,
   output logic          fl_rd,
   output logic [AW-1:0] fl_addr,
   output logic [DW-1:0] fl_wdata,
   input  logic [DW-1:0] fl_rdata
);

   localparam int unsigned WAIT_MAX = max4(VPP_WAIT, PROG_WAIT, ERASE_WAIT, VERIFY_WAIT);
   localparam int unsigned TW       = $clog2(WAIT_MAX + 1);

   generate
      if (AW < 1 || AW > 24) begin : g_bad_aw
         $error("flash_erase_seq: AW out of range");
      end
      if (DW < 8) begin : g_bad_dw
         $error("flash_erase_seq: DW must hold an 8-bit command code");
      end
      if (VPP_WAIT < 1 || PROG_WAIT < 1 || ERASE_WAIT < 1 || VERIFY_WAIT < 1) begin : g_bad_wait
         $error("flash_erase_seq: every wait must be at least one cycle");
      end
      if (PROG_MAX < 1 || PULSE_LIMIT < 1) begin : g_bad_limits
         $error("flash_erase_seq: retry limits must be at least 1");
      end
   endgenerate

   seq_state_t st, st_nx, after_q, after_nx;
   logic          t_load, t_done;
   logic [TW-1:0] t_val;
   logic          addr_clr, addr_step, addr_last;
   logic [AW-1:0] cur_addr;
   logic          pc_clr, pc_inc, pc_full;
   logic          ec_clr, ec_inc, ec_full;
   logic          set_pass, set_fail, clr_flags;
   logic          pass_q, fail_q;
   logic          rd_zero, rd_ones;

   assign rd_zero = (fl_rdata == '0);
   assign rd_ones = (fl_rdata == '1);

   ferase_wait_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_done)
   );

   ferase_addr_walk #(.AW(AW)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (addr_clr),
      .step  (addr_step),
      .addr  (cur_addr),
      .last  (addr_last)
   );

   ferase_limit_cnt #(.LIMIT(PROG_MAX)) u_prog_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pc_clr),
      .inc   (pc_inc),
      .full  (pc_full)
   );

   ferase_limit_cnt #(.LIMIT(PULSE_LIMIT)) u_pulse_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ec_clr),
      .inc   (ec_inc),
      .full  (ec_full)
   );

   // Next-state and control decode
   always_comb begin
      st_nx     = st;
      after_nx  = after_q;
      t_load    = 1'b0;
      t_val     = '0;
      addr_clr  = 1'b0;
      addr_step = 1'b0;
      pc_clr    = 1'b0;
      pc_inc    = 1'b0;
      ec_clr    = 1'b0;
      ec_inc    = 1'b0;
      set_pass  = 1'b0;
      set_fail  = 1'b0;
      clr_flags = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (start) begin
               st_nx     = ST_WAIT;
               after_nx  = ST_PSET;
               t_load    = 1'b1;
               t_val     = TW'(VPP_WAIT - 1);
               addr_clr  = 1'b1;
               pc_clr    = 1'b1;
               ec_clr    = 1'b1;
               clr_flags = 1'b1;
            end
         end
         ST_WAIT: begin
            if (t_done) st_nx = after_q;
         end
         ST_PSET: st_nx = ST_PDATA;
         ST_PDATA: begin
            pc_inc   = 1'b1;
            st_nx    = ST_WAIT;
            after_nx = ST_PVSET;
            t_load   = 1'b1;
            t_val    = TW'(PROG_WAIT - 1);
         end
         ST_PVSET: begin
            st_nx    = ST_WAIT;
            after_nx = ST_PVRD;
            t_load   = 1'b1;
            t_val    = TW'(VERIFY_WAIT - 1);
         end
         ST_PVRD: st_nx = ST_PVCHK;
         ST_PVCHK: begin
            if (rd_zero) begin
               pc_clr = 1'b1;
               if (addr_last) begin
                  addr_clr = 1'b1;
                  st_nx    = ST_ESET;
               end else begin
                  addr_step = 1'b1;
                  st_nx     = ST_PSET;
               end
            end else if (pc_full) begin
               set_fail = 1'b1;
               st_nx    = ST_IDLE;
            end else begin
               st_nx = ST_PSET;
            end
         end
         ST_ESET: st_nx = ST_EGO;
         ST_EGO: begin
            ec_inc   = 1'b1;
            st_nx    = ST_WAIT;
            after_nx = ST_EVSET;
            t_load   = 1'b1;
            t_val    = TW'(ERASE_WAIT - 1);
         end
         ST_EVSET: begin
            st_nx    = ST_WAIT;
            after_nx = ST_EVRD;
            t_load   = 1'b1;
            t_val    = TW'(VERIFY_WAIT - 1);
         end
         ST_EVRD: st_nx = ST_EVCHK;
         ST_EVCHK: begin
            if (rd_ones) begin
               if (addr_last) begin
                  st_nx = ST_RDMODE;
               end else begin
                  addr_step = 1'b1;
                  st_nx     = ST_EVSET;
               end
            end else if (ec_full) begin
               set_fail = 1'b1;
               st_nx    = ST_IDLE;
            end else begin
               st_nx = ST_ESET;
            end
         end
         ST_RDMODE: begin
            set_pass = 1'b1;
            st_nx    = ST_IDLE;
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         after_q <= ST_IDLE;
         pass_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         st <= st_nx;
         if (t_load) after_q <= after_nx;
         if (clr_flags) begin
            pass_q <= 1'b0;
            fail_q <= 1'b0;
         end else begin
            if (set_pass) pass_q <= 1'b1;
            if (set_fail) fail_q <= 1'b1;
         end
      end
   end

   // Bus drive, decoded from the registered state
   always_comb begin
      fl_wr    = 1'b0;
      fl_rd    = 1'b0;
      fl_wdata = '0;
      unique case (st)
         ST_PSET:   begin fl_wr = 1'b1; fl_wdata = DW'(OP_PROG);      end
         ST_PDATA:  begin fl_wr = 1'b1; fl_wdata = '0;                end
         ST_PVSET:  begin fl_wr = 1'b1; fl_wdata = DW'(OP_PROG_VFY);  end
         ST_ESET,
         ST_EGO:    begin fl_wr = 1'b1; fl_wdata = DW'(OP_ERASE);     end
         ST_EVSET:  begin fl_wr = 1'b1; fl_wdata = DW'(OP_ERASE_VFY); end
         ST_RDMODE: begin fl_wr = 1'b1; fl_wdata = DW'(OP_READ);      end
         ST_PVRD,
         ST_EVRD:   fl_rd = 1'b1;
         default:   ;
      endcase
   end

   assign fl_addr = cur_addr;
   assign busy    = (st != ST_IDLE);
   assign vpp_req = busy;
   assign pass    = pass_q;
   assign fail    = fail_q;

   a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_wr && fl_rd));

   a_r2_strobe_needs_vpp: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_wr || fl_rd) |-> vpp_req);

   a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass && fail) && !(busy && (pass || fail)));

   a_r10_pass_after_read_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pass) |-> ($past(fl_wr) && ($past(fl_wdata) == DW'(OP_READ))));

   a_r11_busy_rises_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

endmodule

// File: tb/flash_erase_seq_test.sv
`timescale 1ns/1ps
module flash_erase_seq_test;

   localparam int AW    = 3;
   localparam int NW    = 1 << AW;
   localparam int VPPW  = 2;
   localparam int PW    = 3;
   localparam int EW    = 6;
   localparam int VW    = 2;
   localparam int PMAX  = 3;
   localparam int LIMIT = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          busy, pass, fail, vpp_req, fl_wr, fl_rd;
   logic [AW-1:0] fl_addr;
   logic [15:0]   fl_wdata;
   logic [15:0]   fl_rdata = 16'h0;

   always #2 clk = ~clk;

   flash_erase_seq #(
      .AW(AW), .DW(16), .VPP_WAIT(VPPW), .PROG_WAIT(PW), .ERASE_WAIT(EW),
      .VERIFY_WAIT(VW), .PROG_MAX(PMAX), .PULSE_LIMIT(LIMIT)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .pass(pass),
      .fail(fail), .vpp_req(vpp_req), .fl_wr(fl_wr), .fl_rd(fl_rd),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;

   // ---- behavioural flash: words need a set number of pulses ----
   int   pneed [NW];
   int   eneed [NW];
   int   pc    [NW];
   int   ep = 0;
   int   r5_bad = 0;
   logic [7:0] last_cmd = 8'hFF;
   logic model_clr = 1'b0;

   always @(posedge clk) begin
      if (model_clr) begin
         for (int i = 0; i < NW; i++) pc[i] = 0;
         ep = 0;
         r5_bad = 0;
         last_cmd = 8'hFF;
      end else begin
         if (fl_wr) begin
            if (last_cmd == 8'h40) begin
               pc[fl_addr] = pc[fl_addr] + 1;
               last_cmd = 8'hFF;
            end else if (fl_wdata[7:0] == 8'h20 && last_cmd == 8'h20) begin
               for (int i = 0; i < NW; i++) if (pc[i] < pneed[i]) r5_bad = r5_bad + 1;
               ep = ep + 1;
               last_cmd = 8'hFF;
            end else begin
               last_cmd = fl_wdata[7:0];
            end
         end
         if (fl_rd) begin
            if (last_cmd == 8'hC0)
               fl_rdata <= (pc[fl_addr] >= pneed[fl_addr]) ? 16'h0000 : 16'h00F0;
            else if (last_cmd == 8'hA0)
               fl_rdata <= (ep >= eneed[fl_addr]) ? 16'hFFFF : 16'h7FFF;
            else
               fl_rdata <= 16'h5A5A;
         end
      end
   end

   // ---- expected trace ----
   int    q_slot[$];
   int    q_rd[$];
   int    q_addr[$];
   int    q_ua[$];
   int    q_data[$];
   string q_req[$];
   int    end_slot;
   bit    exp_pass;
   string end_req;

   function automatic void push(int s, int r, int a, int ua, int d, string rq);
      q_slot.push_back(s); q_rd.push_back(r); q_addr.push_back(a);
      q_ua.push_back(ua); q_data.push_back(d); q_req.push_back(rq);
   endfunction

   task automatic build(input int k0);
      int t, p, e, a;
      bit done, ok_w, need_pulse, resumed;
      q_slot.delete(); q_rd.delete(); q_addr.delete();
      q_ua.delete(); q_data.delete(); q_req.delete();
      t = k0 + VPPW;
      done = 0;
      for (int w = 0; w < NW && !done; w++) begin
         p = 0;
         ok_w = 0;
         while (!ok_w && !done) begin
            push(t, 0, w, 0, 'h40, "R3"); t++;
            push(t, 0, w, 1, 0, "R3");    t++; p++;
            t += PW;
            push(t, 0, w, 0, 'hC0, "R3"); t += 1 + VW;
            push(t, 1, w, 1, 0, "R3");    t += 2;
            if (p >= pneed[w]) ok_w = 1;
            else if (p == PMAX) begin
               done = 1; end_slot = t; exp_pass = 0; end_req = "R4";
            end
         end
      end
      e = 0; a = 0; need_pulse = 1; resumed = 0;
      while (!done) begin
         if (need_pulse) begin
            push(t, 0, 0, 0, 'h20, resumed ? "R8" : "R6"); t++;
            push(t, 0, 0, 0, 'h20, resumed ? "R8" : "R6"); t++;
            e++; t += EW; need_pulse = 0;
         end
         push(t, 0, a, 1, 'hA0, resumed ? "R8" : "R6"); t += 1 + VW;
         push(t, 1, a, 1, 0, "R7"); t += 2;
         if (e >= eneed[a]) begin
            resumed = 0;
            if (a == NW - 1) begin
               push(t, 0, 0, 0, 0, "R10");
               end_slot = t + 1; exp_pass = 1; end_req = "R10"; done = 1;
            end else a++;
         end else if (e == LIMIT) begin
            end_slot = t; exp_pass = 0; end_req = "R9"; done = 1;
         end else begin
            need_pulse = 1; resumed = 1;
         end
      end
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One run: cycle-by-cycle comparison against the trace
   task automatic run(input bit extra, input string name);
      int k0;
      bit ok;
      longint act, exp;
      string tg;
      model_clr = 1'b1;
      @(negedge clk);
      model_clr = 1'b0;
      k0 = cyc + 1;
      build(k0);
      start = 1'b1;
      forever begin
         @(negedge clk);
         start = 1'b0;
         if (cyc >= end_slot) begin
            chk(!busy && !vpp_req && pass == exp_pass && fail == !exp_pass && !fl_wr && !fl_rd,
                end_req, {name, " end flags"},
                {busy, vpp_req, pass, fail}, {2'b00, exp_pass, !exp_pass});
            chk(q_slot.size() == 0, end_req, {name, " leftover strobes"}, q_slot.size(), 0);
            break;
         end
         chk(busy && vpp_req && !pass && !fail, "R2 R12", {name, " busy window"},
             {busy, vpp_req, pass, fail}, 4'b1100);
         act = (longint'(fl_wr) << 24) | (longint'(fl_rd) << 20) |
               (longint'(fl_addr) << 16) | longint'(fl_wdata);
         if (q_slot.size() > 0 && q_slot[0] == cyc) begin
            if (q_rd[0] != 0)
               ok = fl_rd && !fl_wr && int'(fl_addr) == q_addr[0];
            else
               ok = fl_wr && !fl_rd && int'(fl_wdata) == q_data[0] &&
                    (q_ua[0] == 0 || int'(fl_addr) == q_addr[0]);
            exp = (q_rd[0] != 0) ? ((64'd1 << 20) | (longint'(q_addr[0]) << 16))
                                 : ((64'd1 << 24) | (longint'(q_addr[0]) << 16) | longint'(q_data[0]));
            chk(ok, q_req[0], $sformatf("%s strobe slot %0d", name, cyc - k0), act, exp);
            void'(q_slot.pop_front()); void'(q_rd.pop_front()); void'(q_addr.pop_front());
            void'(q_ua.pop_front()); void'(q_data.pop_front()); void'(q_req.pop_front());
         end else begin
            tg = (q_req.size() > 0) ? q_req[0] : "R2";
            chk(!fl_wr && !fl_rd, tg, $sformatf("%s quiet slot %0d", name, cyc - k0), act, 0);
         end
         // R11: start pulses while busy, one on a wait slot and one on a strobe
         if (extra && (cyc == k0 + 4 || cyc == k0 + VPPW + 1)) start = 1'b1;
      end
   endtask

   initial begin
      repeat (25000) @(posedge clk);
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < NW; i++) begin pneed[i] = 1; eneed[i] = 1; end
      repeat (3) @(negedge clk);
      chk(!busy && !pass && !fail && !vpp_req && !fl_wr && !fl_rd, "R1", "in reset",
          {busy, pass, fail, vpp_req, fl_wr, fl_rd}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !pass && !fail && !vpp_req && !fl_wr && !fl_rd, "R1", "after reset",
          {busy, pass, fail, vpp_req, fl_wr, fl_rd}, 0);

      // Minimal run: one pulse of each kind per word
      run(0, "single");
      chk(r5_bad == 0, "R5", "single precondition before erase", r5_bad, 0);
      chk(ep == 1, "R9", "single pulse count", ep, 1);

      // Mixed retries, resume at failing word, start pulses while busy
      pneed = '{1, 2, 3, 1, 2, 1, 1, 3};
      eneed = '{1, 3, 2, 1, 4, 1, 1, 2};
      run(1, "mixed");
      chk(r5_bad == 0, "R5", "mixed precondition before erase", r5_bad, 0);
      chk(ep == 4, "R8", "mixed pulse count", ep, 4);

      // Boundary: the last permitted pulse succeeds
      pneed = '{1, 1, 1, 1, 1, 1, 1, 1};
      eneed = '{1, 1, 5, 1, 1, 1, 1, 5};
      run(0, "at_limit");
      chk(ep == LIMIT, "R9", "at_limit pulse count", ep, LIMIT);

      // Over limit: give up after LIMIT pulses
      eneed = '{1, 2, 1, 7, 1, 1, 1, 1};
      run(0, "over_limit");
      chk(ep == LIMIT, "R9", "over_limit pulse count", ep, LIMIT);
      repeat (6) @(negedge clk);
      chk(fail && !pass && !busy && !fl_wr && !fl_rd, "R12", "fail held while idle",
          {fail, pass, busy}, 3'b100);

      // Program retry exhaustion: no erase at all; new start clears fail
      eneed = '{1, 1, 1, 1, 1, 1, 1, 1};
      pneed = '{1, 1, 4, 1, 1, 1, 1, 1};
      run(0, "prog_fail");
      chk(ep == 0, "R5", "prog_fail no erase launched", ep, 0);
      chk(pc[2] == PMAX, "R4", "prog_fail program writes", pc[2], PMAX);

      pneed = '{1, 1, 1, 1, 1, 1, 1, 1};
      run(0, "recover");
      repeat (4) @(negedge clk);
      chk(pass && !fail && !busy, "R12", "pass held while idle", {pass, fail, busy}, 3'b100);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule